// File: doc/BRIEF.md
# Two-Location Host Register Port for a Character Display Controller

This block is the host-facing side of a character display controller. A host bus sees two byte locations. Location 0 selects an internal register and reports a status flag. Location 1 carries data to and from the selected register. Behind the port there are 37 eight-bit registers. Three of them have a fixed job. One pair holds the display memory update address as a high byte and a low byte. A memory data register moves bytes between the host and display memory at that update address. The update address steps forward by one after every memory transfer, so the host can stream a run of bytes with no address writes in between.

The display memory is a single-port array that is shared with video fetches. A video fetch takes the port for the cycle in which it is requested, and host memory transfers wait behind it. This is why a host memory transfer takes a variable number of cycles. The host polls the status flag until it shows ready. Only then may it touch the data port again.

A read of the memory data register does not return data at once. It starts a fetch. When the flag shows ready again, location 1 shows the fetched byte while the select still points at the memory data register.

The memory size `DEPTH` must be a power of two and larger than 256.

Top module: `dispctl_hostport`

## Requirements
- R1: After reset the status flag shows ready, the select value is 0, every general register reads 0, the update address is 0 and the fetched-byte latch reads 0.
- R2: A read of location 0 returns the ready flag in bit 7 and zeros in bits 6..0. A write to location 0 loads the select value, and this is accepted even while a transfer is pending.
- R3: With a select in 0..36 other than 18, 19 and 31, a write to location 1 stores the byte in that register, and location 1 then reads it back.
- R4: Select 18 is the update address high byte and select 19 is the low byte. Both can be read and written through location 1. The high byte keeps only address bits AW-1..8, and its upper unused bits read as 0.
- R5: A write to location 1 with select 31 stores the byte into display memory at the current update address.
- R6: Every completed select-31 transfer, read or write, adds 1 to the update address. The address wraps from DEPTH-1 to 0.
- R7: The ready flag is low in the cycle after a select-31 access is accepted. It goes high again at the clock edge where the memory port is granted. With no video fetch pending, that edge is the very next one.
- R8: A read strobe on location 1 with select 31 fetches the byte at the update address. Once ready returns, location 1 shows that byte while select stays 31.
- R9: An access to location 1 while ready is low is ignored. It changes no register, no memory byte and not the update address.
- R10: With a select above 36, location 1 reads 0xFF, writes to it are ignored, and it starts no transfer.
- R11: A video fetch (vid_fetch high) owns the memory port in that cycle. A pending host transfer waits while vid_fetch stays high. vid_data shows the byte at vid_addr one cycle after the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = select/status location, 1 = data location |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the location on host_addr |
| vid_fetch | input | 1 | Video fetch request for this cycle |
| vid_addr | input | AW | Video fetch address |
| vid_data | output | 8 | Byte fetched for video, valid one cycle after the request |

## Verification
The memory is first filled through one long run of auto-incremented writes. This run tells apart a correct increment from one that is skipped or doubled, and it wraps the address back to 0.

Directed cases cover several conditions:
- Holding vid_fetch high stalls a pending transfer. This separates correct fetch priority from a host transfer that slips through.
- Accesses made while busy must be dropped.
- Out-of-range selects must be ignored.
- The single-step wrap at the top of memory is tried separately.

Random mixes of register writes, memory writes and memory reads then run under random video fetch traffic. Each result is compared with a bench model of the memory, the registers and the address.

// File: rtl/dhp_pkg.sv
package dhp_pkg;
  localparam int NUM_REGS     = 37;
  localparam int REG_ADDR_HI  = 18;
  localparam int REG_ADDR_LO  = 19;
  localparam int REG_MEM_DATA = 31;

  typedef logic [7:0] byte_t;

  // General registers are those without a fixed job
  function automatic logic idx_is_general(input int idx);
    return (idx != REG_ADDR_HI) && (idx != REG_ADDR_LO) && (idx != REG_MEM_DATA);
  endfunction

  function automatic logic sel_in_range(input byte_t sel);
    return int'(sel) < NUM_REGS;
  endfunction
endpackage

// File: rtl/dhp_regfile.sv
module dhp_regfile
  import dhp_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wr_idx,
  input  byte_t wr_data,
  input  byte_t rd_idx,
  output byte_t rd_data
);
  byte_t regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (idx_is_general(g)) begin : g_store
      logic  en;
      byte_t q;
      assign en = wr_en && (int'(wr_idx) == g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wr_data;
      end
      assign regs_q[g] = q;
    end else begin : g_fixed
      // Storage for these indices lives in the transfer engine
      assign regs_q[g] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (int'(rd_idx) == i) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/dhp_xfer.sv
module dhp_xfer
  import dhp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          start_rd,
  input  byte_t         start_data,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  byte_t         ld_data,
  input  logic          vid_fetch,
  output logic          ready,
  output logic          grant,
  output logic          grant_we,
  output byte_t         grant_data,
  output logic [AW-1:0] upd_addr
);
  localparam int            HW   = AW - 8;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          pend_q, pend_d;
  logic          we_q, we_d;
  byte_t         data_q, data_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          xfer_en;

  assign grant      = pend_q && !vid_fetch;
  assign ready      = !pend_q;
  assign grant_we   = we_q;
  assign grant_data = data_q;
  assign upd_addr   = addr_q;
  assign xfer_en    = grant || start_wr || start_rd || ld_hi || ld_lo;

  always_comb begin
    pend_d = pend_q;
    we_d   = we_q;
    data_d = data_q;
    addr_d = addr_q;
    if (grant) begin
      pend_d = 1'b0;
      addr_d = (addr_q == LAST) ? '0 : addr_q + AW'(1);
    end else if (ld_hi) begin
      addr_d[AW-1:8] = ld_data[HW-1:0];
    end else if (ld_lo) begin
      addr_d[7:0] = ld_data;
    end
    if (start_wr || start_rd) begin
      pend_d = 1'b1;
      we_d   = start_wr;
      data_d = start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else if (xfer_en) begin
      pend_q <= pend_d;
      we_q   <= we_d;
      data_q <= data_d;
      addr_q <= addr_d;
    end
  end

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr || start_rd) |=> !ready);
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(grant));
  p_fetch_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && vid_fetch) |=> !ready);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> upd_addr == (($past(upd_addr) == LAST) ? '0 : $past(upd_addr) + AW'(1)));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !grant) |=> $stable(upd_addr));
endmodule

// File: rtl/dhp_dmem.sv
module dhp_dmem
  import dhp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_fetch,
  input  logic [AW-1:0] vid_addr,
  output byte_t         vid_data,
  input  logic          grant,
  input  logic          grant_we,
  input  logic [AW-1:0] grant_addr,
  input  byte_t         grant_data,
  output byte_t         host_q
);
  byte_t mem [DEPTH];
  logic  mem_we, host_rd_en;

  assign mem_we     = grant && grant_we;
  assign host_rd_en = grant && !grant_we;

  always_ff @(posedge clk) begin
    if (mem_we) mem[grant_addr] <= grant_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vid_data <= '0;
    else if (vid_fetch) vid_data <= mem[vid_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          host_q <= '0;
    else if (host_rd_en) host_q <= mem[grant_addr];
  end

  p_port_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vid_fetch |-> !grant);
endmodule

// File: rtl/dispctl_hostport.sv
module dispctl_hostport
  import dhp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          vid_fetch,
  input  logic [AW-1:0] vid_addr,
  output logic [7:0]    vid_data
);
  localparam int HW = AW - 8;

  byte_t         sel_q;
  logic          sel_en;
  logic          ready, grant, grant_we;
  byte_t         grant_data, host_q, rf_rd;
  logic [AW-1:0] upd_addr;
  logic          data_acc, sel_ok;
  logic          start_wr, start_rd, ld_hi, ld_lo, rf_wr;

  assign sel_ok   = sel_in_range(sel_q);
  assign sel_en   = host_req && host_we && !host_addr;
  assign data_acc = host_req && host_addr && ready && sel_ok;
  assign start_wr = data_acc &&  host_we && (int'(sel_q) == REG_MEM_DATA);
  assign start_rd = data_acc && !host_we && (int'(sel_q) == REG_MEM_DATA);
  assign ld_hi    = data_acc &&  host_we && (int'(sel_q) == REG_ADDR_HI);
  assign ld_lo    = data_acc &&  host_we && (int'(sel_q) == REG_ADDR_LO);
  assign rf_wr    = data_acc &&  host_we && idx_is_general(int'(sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= host_wdata;
  end

  dhp_regfile #(.NREGS(NUM_REGS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(rf_wr), .wr_idx(sel_q),
    .wr_data(host_wdata), .rd_idx(sel_q), .rd_data(rf_rd)
  );

  dhp_xfer #(.DEPTH(DEPTH), .AW(AW)) xfer_i (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .start_data(host_wdata), .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_data(host_wdata),
    .vid_fetch(vid_fetch), .ready(ready), .grant(grant), .grant_we(grant_we),
    .grant_data(grant_data), .upd_addr(upd_addr)
  );

  dhp_dmem #(.DEPTH(DEPTH), .AW(AW)) dmem_i (
    .clk(clk), .rst_n(rst_n), .vid_fetch(vid_fetch), .vid_addr(vid_addr),
    .vid_data(vid_data), .grant(grant), .grant_we(grant_we),
    .grant_addr(upd_addr), .grant_data(grant_data), .host_q(host_q)
  );

  always_comb begin
    if (!host_addr)                           host_rdata = {ready, 7'b0};
    else if (!sel_ok)                         host_rdata = 8'hFF;
    else if (int'(sel_q) == REG_ADDR_HI)      host_rdata = 8'(upd_addr[AW-1:8]);
    else if (int'(sel_q) == REG_ADDR_LO)      host_rdata = upd_addr[7:0];
    else if (int'(sel_q) == REG_MEM_DATA)     host_rdata = host_q;
    else                                      host_rdata = rf_rd;
  end

  // An out-of-range data access never starts a transfer
  p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_addr && ready && (sel_q > 8'd36)) |=> ready);
  p_sel_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !host_addr) |=> sel_q == $past(host_wdata));
  initial begin
    p_width_cfg: assert (HW >= 1 && HW <= 8);
  end
endmodule

// File: tb/dispctl_hostport_tb_top.sv
module dispctl_hostport_tb_top;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_req, host_we, host_addr;
  logic [7:0]    host_wdata, host_rdata;
  logic          vid_fetch;
  logic [AW-1:0] vid_addr;
  logic [7:0]    vid_data;

  int checks = 0;
  int errors = 0;
  bit noise_en = 1'b0;
  bit done = 1'b0;

  logic [7:0] mdl_mem [DEPTH];
  logic [7:0] mdl_regs [37];
  int         mdl_addr;

  always #5 clk = ~clk;

  dispctl_hostport #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vid_fetch(vid_fetch), .vid_addr(vid_addr), .vid_data(vid_data)
  );

  function automatic int next_addr(input int a);
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [7:0] fill_byte(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  // Expected location-1 value for a select, from the model
  function automatic logic [7:0] exp_data(input int sel);
    if (sel > 36)  return 8'hFF;
    if (sel == 18) return 8'(mdl_addr >> 8);
    if (sel == 19) return 8'(mdl_addr & 255);
    return mdl_regs[sel];
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd_strobe();
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_ready(output int n);
    logic [7:0] s;
    n = 0;
    peek(1'b0, s);
    while (!s[7] && n < 2000) begin
      @(negedge clk);
      n++;
      peek(1'b0, s);
    end
  endtask

  task automatic vid_peek(input int a, output logic [7:0] v);
    bit keep;
    keep = noise_en;
    noise_en = 1'b0;
    @(negedge clk);
    vid_fetch = 1'b1; vid_addr = AW'(a);
    @(negedge clk);
    vid_fetch = 1'b0;
    v = vid_data;
    noise_en = keep;
  endtask

  task automatic set_addr(input int a);
    host_wr(1'b0, 8'd18); host_wr(1'b1, 8'(a >> 8));
    host_wr(1'b0, 8'd19); host_wr(1'b1, 8'(a & 255));
    mdl_addr = a;
  endtask

  initial begin : noise
    forever begin
      @(negedge clk);
      if (noise_en) begin
        vid_fetch = ($urandom % 3) == 0;
        vid_addr  = AW'($urandom);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    int n;
    void'($urandom(32'h5EED));
    host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    vid_fetch = 0; vid_addr = '0;
    for (int i = 0; i < 37; i++) mdl_regs[i] = 8'h00;
    mdl_addr = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state and status layout
    peek(1'b0, v); check("R1 R2 status after reset", v, 8'h80);
    peek(1'b1, v); check("R1 select 0 register", v, 8'h00);
    host_wr(1'b0, 8'd31); peek(1'b1, v); check("R1 fetch latch", v, 8'h00);
    host_wr(1'b0, 8'd18); peek(1'b1, v); check("R1 addr hi", v, 8'h00);

    // R10: out-of-range select
    host_wr(1'b0, 8'd40); peek(1'b1, v); check("R10 read of select 40", v, 8'hFF);
    host_wr(1'b1, 8'h55); peek(1'b0, v); check("R10 no transfer started", v, 8'h80);
    host_wr(1'b0, 8'd5);  peek(1'b1, v); check("R10 register 5 untouched", v, 8'h00);

    // R5 / R6 / R7: fill memory by auto-increment, with wrap to 0
    set_addr(0);
    host_wr(1'b0, 8'd31);
    for (int i = 0; i < DEPTH; i++) begin
      host_wr(1'b1, fill_byte(i));
      mdl_mem[i] = fill_byte(i);
      if (i == 0) begin
        peek(1'b0, v); check("R7 ready low after access", v, 8'h00);
      end
      wait_ready(n);
      if (i == 0) check("R7 one-cycle grant when idle", 8'(n), 8'd1);
      mdl_addr = next_addr(mdl_addr);
    end
    host_wr(1'b0, 8'd19); peek(1'b1, v); check("R6 wrap lo after fill", v, 8'h00);
    host_wr(1'b0, 8'd18); peek(1'b1, v); check("R6 wrap hi after fill", v, 8'h00);
    vid_peek(0, v);   check("R5 mem[0]", v, mdl_mem[0]);
    vid_peek(517, v); check("R5 mem[517]", v, mdl_mem[517]);
    vid_peek(1023, v); check("R11 R5 mem[1023]", v, mdl_mem[1023]);

    // R11 / R9: stalled transfer, accesses while busy dropped
    set_addr(300);
    host_wr(1'b0, 8'd31);
    @(negedge clk); vid_fetch = 1'b1; vid_addr = AW'(12);
    host_wr(1'b1, 8'hA5);
    host_wr(1'b1, 8'h3C);
    repeat (3) @(negedge clk);
    peek(1'b0, v); check("R11 transfer stalled by fetch", v, 8'h00);
    check("R11 fetch data during stall", vid_data, mdl_mem[12]);
    vid_fetch = 1'b0;
    @(negedge clk);
    peek(1'b0, v); check("R11 transfer done after release", v, 8'h80);
    mdl_mem[300] = 8'hA5; mdl_addr = 301;
    vid_peek(300, v); check("R5 stalled write landed", v, 8'hA5);
    vid_peek(301, v); check("R9 busy write dropped", v, mdl_mem[301]);
    host_wr(1'b0, 8'd19); peek(1'b1, v); check("R9 address stepped once", v, 8'd45);

    // R4: high byte keeps only implemented bits; R6 single-step wrap
    host_wr(1'b0, 8'd18); host_wr(1'b1, 8'hFF); peek(1'b1, v); check("R4 hi masked", v, 8'h03);
    host_wr(1'b0, 8'd19); host_wr(1'b1, 8'hFF); peek(1'b1, v); check("R4 lo", v, 8'hFF);
    mdl_addr = 1023;
    host_wr(1'b0, 8'd31); host_wr(1'b1, 8'h77); wait_ready(n);
    mdl_mem[1023] = 8'h77; mdl_addr = 0;
    host_wr(1'b0, 8'd19); peek(1'b1, v); check("R6 wrap from top", v, 8'h00);
    vid_peek(1023, v); check("R5 top byte", v, 8'h77);

    // R8: memory read through the latch
    set_addr(291);
    host_wr(1'b0, 8'd31); host_rd_strobe(); wait_ready(n);
    peek(1'b1, v); check("R8 fetched byte", v, mdl_mem[291]);
    mdl_addr = 292;
    host_wr(1'b0, 8'd19); peek(1'b1, v); check("R8 R6 address after read", v, 8'h24);

    // Random mix under video traffic
    noise_en = 1'b1;
    for (int it = 0; it < 250; it++) begin
      int op, idx, a;
      logic [7:0] d;
      op = $urandom % 3;
      d = 8'($urandom);
      if (op == 0) begin
        idx = $urandom % 37;
        if (idx == 18 || idx == 19 || idx == 31) idx = 2;
        host_wr(1'b0, 8'(idx)); host_wr(1'b1, d); mdl_regs[idx] = d;
        peek(1'b1, v); check("R3 general register", v, exp_data(idx));
      end else if (op == 1) begin
        a = $urandom % DEPTH;
        set_addr(a);
        host_wr(1'b0, 8'd31); host_wr(1'b1, d); wait_ready(n);
        mdl_mem[a] = d; mdl_addr = next_addr(a);
        vid_peek(a, v); check("R5 random write", v, d);
        host_wr(1'b0, 8'd19); peek(1'b1, v); check("R6 random step", v, exp_data(19));
      end else begin
        a = $urandom % DEPTH;
        set_addr(a);
        host_wr(1'b0, 8'd31); host_rd_strobe(); wait_ready(n);
        peek(1'b1, v); check("R8 random read", v, mdl_mem[a]);
        mdl_addr = next_addr(a);
        host_wr(1'b0, 8'd18); peek(1'b1, v); check("R4 R6 hi after read", v, exp_data(18));
      end
    end
    noise_en = 1'b0;
    for (int i = 0; i < 37; i++) begin
      if (i != 18 && i != 19 && i != 31) begin
        host_wr(1'b0, 8'(i)); peek(1'b1, v); check("R3 final register sweep", v, mdl_regs[i]);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule